// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

The refresh scheduler paces auto-refresh work for a two-bank SDRAM controller. The memory needs 4096 auto-refresh commands in every 64 ms window. Each command refreshes one row, picked by the device's own internal 12-bit row counter, so the command carries no address. The scheduler counts clock cycles and adds one owed refresh at each interval. The interval is the retention window divided by the row count, turned into clocks from the configured clock frequency in kHz, with a small safety margin taken off. While the count of owed refreshes is above zero, the scheduler raises a request to the command sequencer.

The sequencer answers with a one-cycle grant once both banks are precharged and it has issued the auto-refresh. The grant takes one refresh off the owed count. For the next `RFC_CLKS` cycles, while the device is busy with the refresh cycle, the request stays low. The owed count lets a burst of traffic put refresh off without losing any. When the count reaches `MAX_OWED`, the urgent flag rises, and the sequencer must serve refresh before it starts any new access. Precharge, the refresh command itself and self-refresh sequencing belong to the sequencer.

The controller has four states. `ST_IDLE` means nothing is owed. `ST_OWED` means one or more refreshes are owed but the count is below the limit. `ST_URGENT` means the count is at the limit. `ST_RECOVER` means a granted refresh is still occupying the device.

The transitions are as follows:
- From `ST_IDLE`, `ST_OWED` and `ST_URGENT`, the next state follows the updated owed count: zero goes to `ST_IDLE`, the limit goes to `ST_URGENT`, and any other value goes to `ST_OWED`.
- From `ST_OWED` and `ST_URGENT`, an accepted grant goes to `ST_RECOVER`.
- `ST_RECOVER` returns to the state that the owed count selects once its hold time has run out.

Top module: `ref_sched`

## Requirements
- R1: While `rst_n` is low, and just after it rises, `ref_req` and `ref_urgent` are 0 and `ref_owed` is 0. The interval count also restarts from zero.
- R2: The interval is TICK = RETENTION_MS*CLK_KHZ/ROWS − MARGIN_CLKS clocks, using integer division. `ref_owed` first becomes 1 after the (TICK+1)-th rising edge with `rst_n` high. After that, it gains one every TICK clocks.
- R3: Outside the hold window, `ref_req` is 1 exactly when `ref_owed` is nonzero.
- R4: A grant accepted at an edge (`ref_gnt`=1 while `ref_req`=1) lowers `ref_owed` by one at that edge. If an interval ends at the same edge, `ref_owed` stays unchanged.
- R5: `ref_owed` never goes above `MAX_OWED`. An interval that ends while the count is at `MAX_OWED` and no grant is accepted is dropped.
- R6: Outside the hold window, `ref_urgent` is 1 exactly when `ref_owed` equals `MAX_OWED`.
- R7: After an accepted grant, `ref_req` and `ref_urgent` stay 0 for exactly `RFC_CLKS` cycles. The owed count keeps collecting intervals during those cycles.
- R8: A grant while `ref_req` is 0 (idle or holding) is ignored, and `ref_owed` does not drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_gnt | input | 1 | One-cycle grant from the command sequencer: the refresh has been issued |
| ref_req | output | 1 | One or more refreshes owed and the device is free for one |
| ref_urgent | output | 1 | Owed count at its limit; refresh must come before new accesses |
| ref_owed | output | OWED_W | Number of refreshes currently owed |

## Verification
A wrong interval count would show on `ref_owed` as an increment in the wrong cycle. This is visible within one interval of reset, and again at every later interval. A wrong owed count or a wrong state would show in the same cycle as a mismatch between `ref_owed`, `ref_req` and `ref_urgent`. A grant that is wrongly accepted or wrongly dropped would change `ref_owed` at the very next edge. A wrong hold length would show on `ref_req` no more than `RFC_CLKS`+1 cycles after the grant.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OWED    = 2'd1,
        ST_URGENT  = 2'd2,
        ST_RECOVER = 2'd3
    } ref_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int TICK_CLKS = 1550
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= wrap;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ref_owed_counter.sv
module ref_owed_counter #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              take,
    output logic [OWED_W-1:0] owed_q,
    output logic [OWED_W-1:0] owed_d
);
    localparam logic [OWED_W-1:0] FULL = OWED_W'(MAX_OWED);

    logic inc;

    // At the limit a lone interval is dropped; with a grant it still cancels.
    assign inc = tick && ((owed_q != FULL) || take);

    always_comb begin
        unique case ({inc, take})
            2'b10:   owed_d = owed_q + 1'b1;
            2'b01:   owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end
endmodule

// File: rtl/ref_recovery_timer.sv
module ref_recovery_timer #(
    parameter int RFC_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    generate
        if (RFC_CLKS <= 1) begin : g_single
            assign done = 1'b1;
        end else begin : g_count
            localparam int RW = $clog2(RFC_CLKS);
            logic [RW-1:0] left_q;

            always_ff @(posedge clk) begin
                if (!rst_n)              left_q <= '0;
                else if (start)          left_q <= RW'(RFC_CLKS - 1);
                else if (left_q != '0)   left_q <= left_q - 1'b1;
            end

            assign done = (left_q == '0);
        end
    endgenerate
endmodule

// File: rtl/ref_sched.sv
module ref_sched #(
    parameter int CLK_KHZ      = 100000,
    parameter int RETENTION_MS = 64,
    parameter int ROWS         = 4096,
    parameter int MARGIN_CLKS  = 12,
    parameter int MAX_OWED     = 8,
    parameter int RFC_CLKS     = 6,
    parameter int OWED_W       = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [OWED_W-1:0] ref_owed
);
    import ref_sched_pkg::*;

    localparam int TICK_CLKS = (RETENTION_MS * CLK_KHZ) / ROWS - MARGIN_CLKS;
    localparam logic [OWED_W-1:0] FULL = OWED_W'(MAX_OWED);

    ref_state_e        state_q, state_d;
    logic              tick;
    logic              grant_ok;
    logic              rec_done;
    logic [OWED_W-1:0] owed_d;

    ref_interval_timer #(.TICK_CLKS(TICK_CLKS)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ref_owed_counter #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) i_owed (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .take   (grant_ok),
        .owed_q (ref_owed),
        .owed_d (owed_d)
    );

    ref_recovery_timer #(.RFC_CLKS(RFC_CLKS)) i_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (grant_ok),
        .done  (rec_done)
    );

    assign grant_ok = ref_gnt && ((state_q == ST_OWED) || (state_q == ST_URGENT));

    function automatic ref_state_e by_count(input logic [OWED_W-1:0] n);
        if (n == '0)        return ST_IDLE;
        else if (n == FULL) return ST_URGENT;
        else                return ST_OWED;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = by_count(owed_d);
            ST_OWED,
            ST_URGENT:  state_d = grant_ok ? ST_RECOVER : by_count(owed_d);
            ST_RECOVER: state_d = rec_done ? by_count(owed_d) : ST_RECOVER;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ref_req    = (state_q == ST_OWED) || (state_q == ST_URGENT);
        ref_urgent = (state_q == ST_URGENT);
    end
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ref_urgent,
    input logic [OWED_W-1:0] ref_owed
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!ref_req && !ref_urgent)
                else $error("R1 outputs active in reset");
        end
    end

    p_owed_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_owed <= OWED_W'(MAX_OWED));

    p_req_needs_owed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ref_owed != '0));

    p_urgent_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req && ref_owed == OWED_W'(MAX_OWED)));

    p_grant_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> !ref_req);

    p_grant_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (ref_owed <= $past(ref_owed)));

    p_ignored_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && ref_gnt) |=> (ref_owed >= $past(ref_owed)));
endmodule

bind ref_sched ref_sched_chk #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .ref_owed   (ref_owed)
);

// File: tb/test_ref_sched.sv
module test_ref_sched;
    localparam int CLK_P   = 10;
    localparam int KHZ     = 1024;
    localparam int RET     = 64;
    localparam int NROWS   = 4096;
    localparam int MARGIN  = 2;
    localparam int MAXO    = 4;
    localparam int RFC     = 3;
    localparam int W       = $clog2(MAXO + 1);
    localparam int TICK    = RET * KHZ / NROWS - MARGIN;   // 14

    typedef struct packed {
        logic         req;
        logic         urg;
        logic [W-1:0] owed;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_gnt = 1'b0;
    logic         ref_req, ref_urgent;
    logic [W-1:0] ref_owed;

    int checks = 0;
    int failures = 0;
    exp_t sb_q[$];

    // bench model state
    int m_cnt = 0, m_owed = 0, m_left = 0;
    bit m_tick = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ref_sched #(.CLK_KHZ(KHZ), .RETENTION_MS(RET), .ROWS(NROWS),
                .MARGIN_CLKS(MARGIN), .MAX_OWED(MAXO), .RFC_CLKS(RFC)) i_ref_sched (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_owed(ref_owed));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: drives one cycle of grant and pushes what the next edge must give
    task automatic step(input logic g);
        bit   acc;
        exp_t e;
        ref_gnt = g;
        acc = g && (m_left == 0) && (m_owed != 0);          // R8
        if (acc && !m_tick)                         m_owed--;   // R4
        else if (!acc && m_tick && m_owed < MAXO)   m_owed++;   // R2 R5
        if (acc)             m_left = RFC;                      // R7
        else if (m_left > 0) m_left--;
        m_tick = (m_cnt == TICK - 1);
        m_cnt  = m_tick ? 0 : m_cnt + 1;
        e.req  = (m_left == 0) && (m_owed != 0);
        e.urg  = (m_left == 0) && (m_owed == MAXO);
        e.owed = W'(m_owed);
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R3 req", int'(ref_req), int'(e.req));
                check("R6 urgent", int'(ref_urgent), int'(e.urg));
                check("R4 owed", int'(ref_owed), int'(e.owed));
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req in reset", int'(ref_req), 0);
        check("R1 urgent in reset", int'(ref_urgent), 0);
        check("R1 owed in reset", int'(ref_owed), 0);
        rst_n = 1'b1;

        // first interval, with a stray grant while idle (R8)
        for (int i = 0; i < TICK; i++) step(i == 3);
        check("R8 idle grant ignored / R2 before first interval", int'(ref_owed), 0);
        step(1'b0);
        check("R2 first interval", int'(ref_owed), 1);
        check("R3 req after first interval", int'(ref_req), 1);
        for (int i = 0; i < TICK; i++) step(1'b0);
        check("R2 second interval", int'(ref_owed), 2);

        // saturate
        for (int i = 0; i < 4 * TICK; i++) step(1'b0);
        check("R5 saturated", int'(ref_owed), MAXO);
        check("R6 urgent at limit", int'(ref_urgent), 1);

        // one grant, then grants during the hold window
        step(1'b1);
        check("R4 grant decrements", int'(ref_owed), MAXO - 1);
        check("R7 req low in hold", int'(ref_req), 0);
        check("R7 urgent low in hold", int'(ref_urgent), 0);
        step(1'b1);
        step(1'b1);
        check("R8 hold grants ignored", int'(ref_owed) >= MAXO - 1 ? 1 : 0, 1);
        check("R7 req still low", int'(ref_req), 0);
        step(1'b0);
        check("R7 req back after hold", int'(ref_req), 1);

        // drain with grant held high
        for (int i = 0; i < 6 * TICK; i++) step(1'b1);
        for (int i = 0; i < 5 * TICK; i++) step(1'b0);
        // sparse grants, covers grant and interval on the same edge
        for (int i = 0; i < 30 * TICK; i++) step((i % 5) == 0);
        for (int i = 0; i < 20 * TICK; i++) step((i % 13) == 0);
        for (int i = 0; i < 4; i++) step(1'b0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule